// File: doc/BRIEF.md
# Paged Host Window Decoder

This block sits between an 8-bit host bus and a board that carries a serial communications controller and 256 KB of shared RAM. The host sees a 16 KB window. Each access is steered to one of five targets: a fixed bank at the bottom of shared RAM, a bank that moves under control of a page register, the page register itself, a shared range for interrupt acknowledge on reads and a modem-control (DTR) latch on writes, and the controller's register file. The block forms the 18-bit RAM address and the chip selects, and it holds the controller reset and the RAM enable.

Decode is combinational on the access cycle. The host qualifies each access with `win_cs` and a one-cycle `rd_stb` or `wr_stb`. Read data returns on `rd_data` in the same cycle. The write data bus `wr_data` goes straight to the RAM and to the controller. The page register, the DTR latch, the reset hold and the RAM enable are registered. A change to any of them affects outputs from the cycle after the strobe.

Two side effects work as control. Reading the page-register range puts the controller into reset and holds it there until the page range is next written. Shared RAM is kept disabled from system reset until the DTR range is first written.

Top module: `hpw_window`

## Requirements
- R1: With RAM enabled, an access to offsets 0x0000–0x1CFF asserts `ram_cs` with `ram_addr` equal to the offset. Reads return `ram_rdata`, and `ram_we` follows `wr_stb`.
- R2: With RAM enabled, an access to offsets 0x2000–0x3FFF asserts `ram_cs` with `ram_addr` = page × 0x2000 + (offset − 0x2000). For example, page 2 and offset 0x2000 give 0x04000.
- R3: A write anywhere in 0x1D00–0x1DFF loads the page register from `wr_data[4:0]`, and bits 7:5 are ignored. The new page applies from the next cycle. A read of this range returns 0xFF.
- R4: A read anywhere in 0x1E00–0x1EFF returns `iack_vec` on `rd_data` and pulses `iack_stb` for that cycle.
- R5: A write anywhere in 0x1E00–0x1EFF loads `dtr` from `wr_data[0]` (1 = on) in the next cycle, and bits 7:1 are ignored.
- R6: An access to 0x1F00–0x1FFF asserts `ctl_cs` with `ctl_idx` equal to `offset[7:0]`. `ctl_we` follows `wr_stb`, and reads return `ctl_rdata`.
- R7: A read of 0x1D00–0x1DFF raises `ctl_reset` from the next cycle. It stays high through any other accesses and falls in the cycle after the next write to 0x1D00–0x1DFF.
- R8: `ram_en` is 0 after system reset. It becomes 1 in the cycle after the first write to 0x1E00–0x1EFF and then stays 1.
- R9: While `ram_en` is 0, memory-range accesses assert neither `ram_cs` nor `ram_we`, and reads return 0xFF.
- R10: Without `win_cs`, or without a strobe, no select or strobe output is asserted and no register changes. `rd_data` is 0xFF whenever no read is decoded.
- R11: After system reset the page is 0, `dtr` is 0 and `ctl_reset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| win_cs | input | 1 | Window chip select |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| win_addr | input | 14 | Offset within the 16 KB window |
| wr_data | input | 8 | Host write data, also fed to RAM and controller |
| rd_data | output | 8 | Host read data |
| ram_addr | output | 18 | Shared RAM byte address |
| ram_cs | output | 1 | Shared RAM select |
| ram_we | output | 1 | Shared RAM write enable |
| ram_rdata | input | 8 | Shared RAM read data |
| ctl_cs | output | 1 | Controller register-file select |
| ctl_we | output | 1 | Controller register write |
| ctl_idx | output | 8 | Controller register index |
| ctl_rdata | input | 8 | Controller register read data |
| iack_stb | output | 1 | Interrupt-acknowledge strobe to controller |
| iack_vec | input | 8 | Vector driven by controller during acknowledge |
| ctl_reset | output | 1 | Controller reset, active high |
| ram_en | output | 1 | Shared RAM enable |
| dtr | output | 1 | Modem DTR control |

## Verification
The hardest state to reach is a controller reset that is held across unrelated traffic. A read of the write-only page range sets the hold, and only a later page write releases it. Random stimulus alone seldom keeps such a pair apart with many accesses in between, so a directed sequence does it, and the random phase weights page-range reads and writes so that the hold is entered and left many times. The disabled-RAM phase is also short-lived, because one DTR write ends it for good. The bench therefore runs memory reads and writes right after reset, before any DTR-range write.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  localparam int OFF_W  = 14;
  localparam int PAGE_W = 5;
  localparam int BANK_W = 13;
  localparam int RAM_AW = PAGE_W + BANK_W;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_LOW,
    TGT_HIGH,
    TGT_PAGE,
    TGT_IACK,
    TGT_REGS
  } tgt_e;

  // Classify an offset by its upper bits.
  function automatic tgt_e classify(input logic [OFF_W-1:0] off);
    logic [4:0] blk;
    blk = off[12:8];
    if (off[13])            return TGT_HIGH;
    else if (blk < 5'h1D)   return TGT_LOW;
    else if (blk == 5'h1D)  return TGT_PAGE;
    else if (blk == 5'h1E)  return TGT_IACK;
    else                    return TGT_REGS;
  endfunction

  // RAM address for the two memory banks.
  function automatic logic [RAM_AW-1:0] ram_map(input logic [OFF_W-1:0] off,
                                                 input logic [PAGE_W-1:0] page);
    if (off[13]) return {page, off[BANK_W-1:0]};
    else         return {{PAGE_W{1'b0}}, off[BANK_W-1:0]};
  endfunction
endpackage

// File: rtl/hpw_decode.sv
module hpw_decode
  import hpw_pkg::*;
(
  input  logic              win_cs,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [OFF_W-1:0]  win_addr,
  output tgt_e              tgt,
  output logic              acc_rd,
  output logic              acc_wr
);
  logic live;
  assign live   = win_cs & (rd_stb | wr_stb);
  assign acc_rd = live & rd_stb;
  assign acc_wr = live & wr_stb;
  assign tgt    = live ? classify(win_addr) : TGT_NONE;
endmodule

// File: rtl/hpw_ctrl.sv
module hpw_ctrl
  import hpw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_wr_ev,
  input  logic              page_rd_ev,
  input  logic              dtr_wr_ev,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page_q,
  output logic              dtr_q,
  output logic              rst_hold_q,
  output logic              ram_en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      dtr_q      <= 1'b0;
      rst_hold_q <= 1'b0;
      ram_en_q   <= 1'b0;
    end else begin
      if (page_wr_ev) begin
        page_q     <= wr_data[PAGE_W-1:0];
        rst_hold_q <= 1'b0;
      end else if (page_rd_ev) begin
        rst_hold_q <= 1'b1;
      end
      if (dtr_wr_ev) begin
        dtr_q    <= wr_data[0];
        ram_en_q <= 1'b1;
      end
    end
  end

  a_r3_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr_ev |=> page_q == $past(wr_data[PAGE_W-1:0]));
  a_r7_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
    page_rd_ev |=> rst_hold_q);
  a_r7_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hold_q && !page_wr_ev) |=> rst_hold_q);
  a_r8_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en_q |=> ram_en_q);
  a_r5_dtr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !dtr_wr_ev |=> $stable(dtr_q));
endmodule

// File: rtl/hpw_window.sv
module hpw_window
  import hpw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                win_cs,
  input  logic                rd_stb,
  input  logic                wr_stb,
  input  logic [OFF_W-1:0]    win_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic                ram_cs,
  output logic                ram_we,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic                ctl_cs,
  output logic                ctl_we,
  output logic [7:0]          ctl_idx,
  input  logic [DATA_W-1:0]   ctl_rdata,
  output logic                iack_stb,
  input  logic [DATA_W-1:0]   iack_vec,
  output logic                ctl_reset,
  output logic                ram_en,
  output logic                dtr
);
  tgt_e              tgt;
  logic              acc_rd, acc_wr;
  logic [PAGE_W-1:0] page_q;
  logic              mem_hit;
  logic              page_wr_ev, page_rd_ev, dtr_wr_ev;

  hpw_decode u_dec (
    .win_cs(win_cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .win_addr(win_addr), .tgt(tgt), .acc_rd(acc_rd), .acc_wr(acc_wr)
  );

  assign page_wr_ev = (tgt == TGT_PAGE) & acc_wr;
  assign page_rd_ev = (tgt == TGT_PAGE) & acc_rd;
  assign dtr_wr_ev  = (tgt == TGT_IACK) & acc_wr;

  hpw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .page_wr_ev(page_wr_ev), .page_rd_ev(page_rd_ev), .dtr_wr_ev(dtr_wr_ev),
    .wr_data(wr_data), .page_q(page_q), .dtr_q(dtr),
    .rst_hold_q(ctl_reset), .ram_en_q(ram_en)
  );

  assign mem_hit  = ((tgt == TGT_LOW) | (tgt == TGT_HIGH)) & ram_en;
  assign ram_addr = ram_map(win_addr, page_q);
  assign ram_cs   = mem_hit;
  assign ram_we   = mem_hit & acc_wr;
  assign ctl_cs   = (tgt == TGT_REGS);
  assign ctl_we   = ctl_cs & acc_wr;
  assign ctl_idx  = win_addr[7:0];
  assign iack_stb = (tgt == TGT_IACK) & acc_rd;

  always_comb begin
    rd_data = '1;
    if (acc_rd) begin
      if (mem_hit)        rd_data = ram_rdata;
      else if (ctl_cs)    rd_data = ctl_rdata;
      else if (iack_stb)  rd_data = iack_vec;
    end
  end

  a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, ctl_cs, iack_stb}));
  a_r9_ram_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en |-> !ram_cs && !ram_we);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !win_cs |-> !ram_cs && !ctl_cs && !iack_stb && !ram_we);
  a_r10_idle_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !win_cs |=> $stable(page_q) && $stable(dtr) && $stable(ctl_reset));
endmodule

// File: tb/hpw_window_tb.sv
module hpw_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_cs = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [13:0] win_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data, ram_rdata, ctl_rdata, ctl_idx;
  logic [7:0]  iack_vec = 8'h30;
  logic [17:0] ram_addr;
  logic        ram_cs, ram_we, ctl_cs, ctl_we, iack_stb, ctl_reset, ram_en, dtr;

  int checks = 0;
  int errors = 0;
  int m_page = 0;
  bit m_dtr = 0, m_en = 0, m_hold = 0;

  always #5 clk = ~clk;

  assign ram_rdata = ram_addr[7:0] ^ ram_addr[15:8] ^ {6'd0, ram_addr[17:16]};
  assign ctl_rdata = ctl_idx ^ 8'h33;

  hpw_window u_dut (
    .clk(clk), .rst_n(rst_n), .win_cs(win_cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .win_addr(win_addr), .wr_data(wr_data), .rd_data(rd_data),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .ctl_cs(ctl_cs), .ctl_we(ctl_we), .ctl_idx(ctl_idx), .ctl_rdata(ctl_rdata),
    .iack_stb(iack_stb), .iack_vec(iack_vec), .ctl_reset(ctl_reset),
    .ram_en(ram_en), .dtr(dtr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int region(input int off);
    if (off >= 'h2000) return 2;
    if (off < 'h1D00)  return 1;
    if (off < 'h1E00)  return 3;
    if (off < 'h1F00)  return 4;
    return 5;
  endfunction

  function automatic int exp_addr(input int off);
    if (off >= 'h2000) return m_page * 'h2000 + (off - 'h2000);
    return off;
  endfunction

  function automatic int stub_ram(input int a);
    return (a & 'hFF) ^ ((a >> 8) & 'hFF) ^ ((a >> 16) & 3);
  endfunction

  task automatic check_state(input string tag);
    chk({"R7 ctl_reset ", tag}, int'(ctl_reset), int'(m_hold));
    chk({"R8 ram_en ", tag}, int'(ram_en), int'(m_en));
    chk({"R5 dtr ", tag}, int'(dtr), int'(m_dtr));
  endtask

  task automatic access(input bit cs, input bit rd, input bit wr, input int off,
                        input logic [7:0] d, input logic [7:0] vec);
    int rg;
    int exp_rd;
    bit live, exp_ram, exp_ctl, exp_iack;
    @(negedge clk);
    check_state("pre");
    win_cs = cs; rd_stb = rd; wr_stb = wr; win_addr = off[13:0];
    wr_data = d; iack_vec = vec;
    #1;
    rg = region(off);
    live = cs && (rd || wr);
    exp_ram  = live && (rg == 1 || rg == 2) && m_en;
    exp_ctl  = live && rg == 5;
    exp_iack = live && rd && rg == 4;
    exp_rd = 'hFF;
    if (live && rd) begin
      if (exp_ram) exp_rd = stub_ram(exp_addr(off));
      else if (exp_ctl) exp_rd = (off & 'hFF) ^ 'h33;
      else if (exp_iack) exp_rd = vec;
    end
    chk(rg == 2 ? "R2 ram_cs" : (m_en ? "R1 ram_cs" : "R9 ram_cs"), int'(ram_cs), int'(exp_ram));
    chk("R9 ram_we", int'(ram_we), int'(exp_ram && wr));
    chk("R6 ctl_cs", int'(ctl_cs), int'(exp_ctl));
    chk("R6 ctl_we", int'(ctl_we), int'(exp_ctl && wr));
    chk("R4 iack_stb", int'(iack_stb), int'(exp_iack));
    chk("R10 rd_data", int'(rd_data), exp_rd);
    if (exp_ram) chk(rg == 2 ? "R2 ram_addr" : "R1 ram_addr", int'(ram_addr), exp_addr(off));
    if (exp_ctl) chk("R6 ctl_idx", int'(ctl_idx), off & 'hFF);
    @(posedge clk);
    if (live) begin
      if (rg == 3 && wr) begin m_page = d & 'h1F; m_hold = 0; end
      else if (rg == 3 && rd) m_hold = 1;
      if (rg == 4 && wr) begin m_dtr = d[0]; m_en = 1; end
    end
    @(negedge clk);
    win_cs = 0; rd_stb = 0; wr_stb = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 ctl_reset", int'(ctl_reset), 0);
    chk("R11 dtr", int'(dtr), 0);
    chk("R8 ram_en at reset", int'(ram_en), 0);
    rst_n = 1'b1;
    // R9 memory disabled before any DTR write
    access(1, 1, 0, 'h0100, 8'h00, 8'h00);
    access(1, 0, 1, 'h2345, 8'h77, 8'h00);
    // R3: page read returns FF, and R7 reset hold
    access(1, 1, 0, 'h1D40, 8'h00, 8'h00);
    access(1, 1, 0, 'h1F1A, 8'h00, 8'h00);   // R6 index 0x1A while held
    access(0, 1, 0, 'h1D00, 8'h00, 8'h00);   // R10 no cs
    access(1, 0, 1, 'h1DFF, 8'hE2, 8'h00);   // R3 page=2, bits 7:5 ignored
    // R5/R8 first DTR write with bit0=1 enables RAM
    access(1, 0, 1, 'h1E05, 8'h01, 8'h00);
    access(1, 1, 0, 'h2000, 8'h00, 8'h00);   // R2 page 2 -> 0x4000
    access(1, 1, 0, 'h3FFF, 8'h00, 8'h00);
    access(1, 1, 0, 'h1CFF, 8'h00, 8'h00);   // R1 top of low bank
    access(1, 0, 1, 'h1E80, 8'hFE, 8'h00);   // R5 bits 7:1 ignored -> dtr 0
    access(1, 1, 0, 'h1E00, 8'h00, 8'h30);   // R4 vector 0x30
    access(1, 0, 0, 'h1F00, 8'h00, 8'h00);   // R10 no strobe
    for (int i = 0; i < 1500; i++) begin
      int r, off;
      bit rd;
      r = $urandom % 12;
      case (r)
        0, 1, 2: off = $urandom % 'h1D00;
        3, 4, 5: off = 'h2000 + ($urandom % 'h2000);
        6, 7:    off = 'h1D00 + ($urandom % 'h100);
        8, 9:    off = 'h1E00 + ($urandom % 'h100);
        default: off = 'h1F00 + ($urandom % 'h100);
      endcase
      rd = $urandom % 2;
      access(($urandom % 10) != 0, rd, !rd, off, 8'($urandom), 8'($urandom));
    end
    @(negedge clk);
    check_state("end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule